// File: doc/BRIEF.md
# Interrupt Priority Chain Node

This block sits in one device on a host-bus interrupt daisy chain. It receives an active-low priority signal from the device upstream and keeps a local interrupt request pending. When the host acknowledges an interrupt, the block places its vector byte on the bus, but only if this device holds priority and has a request pending. Taking the vector retires the pending request.

The downstream pin serves two purposes, and a mode input selects between them. In chain mode the pin passes priority on to the next device. While a local request is pending, the pin is forced high, which blocks the devices further down the chain. In disconnect mode the chain is cut, and the same pin reports a disconnect status that arrives as a plain input. The vector byte is held in a register that the surrounding logic loads. The mode bit and the disconnect status are also plain inputs.

Top module: `intc_daisy_node`

## Requirements
- R1: After a synchronous active-low reset, no request is pending and the vector register holds 0. With no request pending, chain mode passes the priority input to the output pin.
- R2: A high on `irq_req` at a clock edge makes a request pending from the next cycle on. The request stays pending, whatever the other inputs do, until it is granted.
- R3: In chain mode (`disc_mode`=0), while a request is pending, `prio_out` is 1 whatever the level of `prio_in_n`.
- R4: In chain mode, while no request is pending, `prio_out` equals `prio_in_n` in the same cycle.
- R5: In disconnect mode (`disc_mode`=1), `prio_out` equals `disc_stat` in the same cycle: 1 while disconnected and 0 otherwise. Pending state and `prio_in_n` have no effect on it.
- R6: `vec_en` is 1 in a cycle exactly when `iack` is 1, a request is pending and `prio_in_n` is 0. This holds in both modes.
- R7: `vec_out` carries the vector register while `vec_en` is 1 and is 0 otherwise.
- R8: A grant cycle (`vec_en`=1) clears the pending request at its closing clock edge. The exception is a grant cycle in which `irq_req` is also 1: the request then stays pending.
- R9: A high on `vec_load` at a clock edge loads `vec_data` into the vector register. The register keeps its value otherwise.
- R10: An `iack` while `prio_in_n` is 1 has no effect. `vec_en` stays 0 and the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prio_in_n | input | 1 | Priority from the upstream device, active low |
| irq_req | input | 1 | Local interrupt request, sampled at each edge |
| iack | input | 1 | Interrupt-acknowledge strobe from the host |
| disc_mode | input | 1 | 0: pin carries the chain, 1: pin reports disconnect |
| disc_stat | input | 1 | Disconnect status, 1 = disconnected |
| vec_load | input | 1 | Load strobe for the vector register |
| vec_data | input | VEC_W | New vector value |
| prio_out | output | 1 | Downstream priority or disconnect indicator |
| vec_en | output | 1 | Vector is being driven this cycle |
| vec_out | output | VEC_W | Vector byte, 0 while not enabled |

## Verification
The pin is driven with both levels of the upstream priority, with and without a pending request, in each mode. This separates a pin that passes priority through from one that is blocked by a pending request, and from one that reports only the disconnect status. Acknowledges are applied in four situations: with priority asserted, with priority withheld, with no request pending, and together with a fresh request. These show that a grant needs all three conditions, that a withheld acknowledge leaves the request intact, and that a request arriving in the grant cycle survives. The vector is read once before any load and once after a load, which tells the reset value apart from the loaded value.

// File: rtl/intc_pkg.sv
// Shared definitions for the interrupt priority chain node.
// Assumes only that users import it before their module headers.
package intc_pkg;
    // Meaning of the pin mode input
    typedef enum logic {
        PIN_CHAIN = 1'b0,
        PIN_DISC  = 1'b1
    } pin_mode_e;
endpackage

// File: rtl/intc_pend_track.sv
// Pending-request tracker: holds a local interrupt request until it is granted.
// Assumes irq_req and grant are synchronous to clk. A request that arrives in
// the grant cycle wins, so the device stays pending.
module intc_pend_track (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic grant,
    output logic pend
);
    // Set on request, clear on grant, request has priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (irq_req)
            pend <= 1'b1;
        else if (grant)
            pend <= 1'b0;
    end
endmodule

// File: rtl/intc_vec_reg.sv
// Vector register with a gated bus output.
// Assumes load is a single-cycle strobe; output is zero unless drive is high.
module intc_vec_reg #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VEC_W-1:0] din,
    input  logic             drive,
    output logic [VEC_W-1:0] dout
);
    localparam logic [VEC_W-1:0] VEC_ZERO = '0;

    logic [VEC_W-1:0] vec_q;

    // Capture a new vector on load, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= VEC_ZERO;
        else if (load)
            vec_q <= din;
    end

    // Present the vector only while the bus is granted
    always_comb begin
        dout = drive ? vec_q : VEC_ZERO;
    end
endmodule

// File: rtl/intc_chain_mux.sv
// Downstream pin selector and grant decode.
// Assumes all inputs are settled within the cycle; purely combinational.
module intc_chain_mux
    import intc_pkg::*;
(
    input  logic prio_in_n,
    input  logic pend,
    input  logic iack,
    input  logic mode,
    input  logic disc_stat,
    output logic pin_out,
    output logic grant
);
    pin_mode_e mode_e;

    // Interpret the raw mode input
    always_comb begin
        mode_e = pin_mode_e'(mode);
    end

    // Pick chain or disconnect meaning for the pin
    always_comb begin
        unique case (mode_e)
            PIN_CHAIN: pin_out = pend | prio_in_n;
            PIN_DISC:  pin_out = disc_stat;
            default:   pin_out = 1'b1;
        endcase
    end

    // Grant needs acknowledge, a pending request and held priority
    always_comb begin
        grant = iack & pend & ~prio_in_n;
    end
endmodule

// File: rtl/intc_daisy_node.sv
// Interrupt priority chain node: pending tracking, vector output and a
// two-mode downstream pin. Assumes the mode bit and the disconnect status are
// decoded elsewhere and arrive synchronous to clk.
module intc_daisy_node #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prio_in_n,
    input  logic             irq_req,
    input  logic             iack,
    input  logic             disc_mode,
    input  logic             disc_stat,
    input  logic             vec_load,
    input  logic [VEC_W-1:0] vec_data,
    output logic             prio_out,
    output logic             vec_en,
    output logic [VEC_W-1:0] vec_out
);
    logic pend_q;
    logic grant_w;

    intc_pend_track u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .grant   (grant_w),
        .pend    (pend_q)
    );

    intc_chain_mux u_mux (
        .prio_in_n (prio_in_n),
        .pend      (pend_q),
        .iack      (iack),
        .mode      (disc_mode),
        .disc_stat (disc_stat),
        .pin_out   (prio_out),
        .grant     (grant_w)
    );

    intc_vec_reg #(.VEC_W(VEC_W)) u_vec (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (vec_load),
        .din   (vec_data),
        .drive (grant_w),
        .dout  (vec_out)
    );

    // Export the grant decode as the vector-enable port
    always_comb begin
        vec_en = grant_w;
    end
endmodule

// File: rtl/intc_daisy_chk.sv
// Property checker for the interrupt priority chain node, attached by bind.
module intc_daisy_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prio_in_n,
    input logic             irq_req,
    input logic             disc_mode,
    input logic             disc_stat,
    input logic             prio_out,
    input logic             vec_en,
    input logic [VEC_W-1:0] vec_out,
    input logic             pend
);
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !vec_en) |=> pend); // R2
    AST_PEND_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!disc_mode && pend) |-> prio_out); // R3
    AST_PASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!disc_mode && !pend) |-> (prio_out == prio_in_n)); // R4
    AST_DISC_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        disc_mode |-> (prio_out == disc_stat)); // R5
    AST_VEC_NEEDS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        vec_en |-> (!prio_in_n && pend)); // R6
    AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_en |-> (vec_out == '0)); // R7
    AST_GRANT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_en && !irq_req) |=> !pend); // R8
endmodule

bind intc_daisy_node intc_daisy_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prio_in_n (prio_in_n),
    .irq_req   (irq_req),
    .disc_mode (disc_mode),
    .disc_stat (disc_stat),
    .prio_out  (prio_out),
    .vec_en    (vec_en),
    .vec_out   (vec_out),
    .pend      (pend_q)
);

// File: tb/sim_intc_daisy_node.sv
// Directed bench for the interrupt priority chain node.
module sim_intc_daisy_node;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prio_in_n = 1'b1;
    logic       irq_req = 1'b0;
    logic       iack = 1'b0;
    logic       disc_mode = 1'b0;
    logic       disc_stat = 1'b0;
    logic       vec_load = 1'b0;
    logic [7:0] vec_data = 8'h00;
    logic       prio_out;
    logic       vec_en;
    logic [7:0] vec_out;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    intc_daisy_node #(.VEC_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .prio_in_n(prio_in_n), .irq_req(irq_req),
        .iack(iack), .disc_mode(disc_mode), .disc_stat(disc_stat),
        .vec_load(vec_load), .vec_data(vec_data),
        .prio_out(prio_out), .vec_en(vec_en), .vec_out(vec_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance to the next falling edge and let logic settle
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        prio_in_n = 1'b0;
        #1;
        chk("R1 pin low after reset", {7'd0, prio_out}, 8'd0);
        prio_in_n = 1'b1;
        #1;
        chk("R1 pin high after reset", {7'd0, prio_out}, 8'd1);
        chk("R1 no vector after reset", {7'd0, vec_en}, 8'd0);
    endtask

    task automatic t_reset_vector();
        irq_req = 1'b1; step(); irq_req = 1'b0;
        prio_in_n = 1'b0; iack = 1'b1; #1;
        chk("R6 grant", {7'd0, vec_en}, 8'd1);
        chk("R1 R9 vector reset value", vec_out, 8'h00);
        step(); iack = 1'b0; #1;
        chk("R8 grant retires", {7'd0, prio_out}, 8'd0);
    endtask

    task automatic t_load_and_grant();
        vec_data = 8'hA5; vec_load = 1'b1; step(); vec_load = 1'b0; vec_data = 8'h3C;
        irq_req = 1'b1; step(); irq_req = 1'b0;
        prio_in_n = 1'b0; #1;
        chk("R3 blocked prio low", {7'd0, prio_out}, 8'd1);
        prio_in_n = 1'b1; iack = 1'b1; #1;
        chk("R3 blocked prio high", {7'd0, prio_out}, 8'd1);
        chk("R10 no grant without prio", {7'd0, vec_en}, 8'd0);
        chk("R7 quiet vector", vec_out, 8'h00);
        step(); iack = 1'b0; prio_in_n = 1'b0; #1;
        chk("R10 still pending", {7'd0, prio_out}, 8'd1);
        iack = 1'b1; #1;
        chk("R6 grant after hold", {7'd0, vec_en}, 8'd1);
        chk("R7 R9 loaded vector", vec_out, 8'hA5);
        step(); iack = 1'b0; #1;
        chk("R8 cleared after grant", {7'd0, prio_out}, 8'd0);
    endtask

    task automatic t_iack_idle();
        prio_in_n = 1'b0; iack = 1'b1; #1;
        chk("R6 no grant without pending", {7'd0, vec_en}, 8'd0);
        step(); iack = 1'b0; #1;
        chk("R4 idle pass", {7'd0, prio_out}, 8'd0);
    endtask

    task automatic t_grant_with_request();
        irq_req = 1'b1; step();
        prio_in_n = 1'b0; iack = 1'b1; #1;
        chk("R6 grant with request", {7'd0, vec_en}, 8'd1);
        step(); iack = 1'b0; irq_req = 1'b0; #1;
        chk("R8 request survives grant", {7'd0, prio_out}, 8'd1);
        repeat (5) step();
        chk("R2 pending held", {7'd0, prio_out}, 8'd1);
    endtask

    task automatic t_disc_mode();
        disc_mode = 1'b1; disc_stat = 1'b0; prio_in_n = 1'b1; #1;
        chk("R5 connected pin low", {7'd0, prio_out}, 8'd0);
        disc_stat = 1'b1; prio_in_n = 1'b0; #1;
        chk("R5 disconnected pin high", {7'd0, prio_out}, 8'd1);
        iack = 1'b1; #1;
        chk("R6 grant in disc mode", {7'd0, vec_en}, 8'd1);
        step(); iack = 1'b0; disc_stat = 1'b0; #1;
        chk("R5 pin follows status", {7'd0, prio_out}, 8'd0);
        disc_mode = 1'b0; #1;
        chk("R4 back to chain", {7'd0, prio_out}, 8'd0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_reset_vector();
                t_load_and_grant();
                t_iack_idle();
                t_grant_with_request();
                t_disc_mode();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule